// File: doc/BRIEF.md
# Streaming Segmented Reduction Unit

This block follows a vector arithmetic stage and turns a stream of signed integer elements into one of three kinds of output stream. A single configuration handshake starts an operation and supplies the output mode, the reduction operator, the number of input elements and, for segmented operation, the segment length. The block then consumes exactly that many elements from its valid/ready input. It produces a valid/ready output stream and marks the final result of the operation with a last flag.

The three modes work as follows. In pass-through mode every element is forwarded unchanged. In whole-stream mode all elements collapse into a single result. In segmented mode the stream is cut into consecutive runs of the configured length, and each run yields one partial result. The operator is sum, signed minimum or signed maximum.

Backpressure on the output stalls the input without losing or repeating any element. A new operation is accepted only once the final result of the current one has been taken.

Top module: `seg_reduce_stream`

## Requirements
- R1: The operator code `cfg_op` selects 0 = sum, 1 = minimum and 2 = maximum, and code 3 acts as sum. Sums wrap modulo 2^32.
- R2: With `cfg_mode` = 0 (code 3 acts the same), N input elements give exactly N outputs. Each output equals its input, in order, and `out_last` is high only on the Nth.
- R3: With `cfg_mode` = 1, exactly one output is produced, whatever the element count. It is the reduction of all `cfg_total` elements, with `out_last` high. This includes a count of 1.
- R4: With `cfg_mode` = 2, the input is cut into consecutive segments of `cfg_seg` elements, and one output is produced per segment. A final short segment still produces an output, so there are ceil(total/seg) outputs, with `out_last` high only on the last one. A segment length of 1 or of at least the total is allowed.
- R5: Minimum and maximum compare the elements as two's-complement signed 32-bit values.
- R6: Each segment's reduction starts from that segment's first element, not from a constant identity. An all-negative segment therefore reduces under maximum to its largest negative element.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold and `out_valid` stays high. Input elements are stalled rather than dropped or repeated.
- R8: `cfg_ready` is high only when no operation is in progress. A configuration offered during an operation is ignored. `cfg_ready` rises in the cycle after the final output has been taken.
- R9: After reset, `out_valid` and `in_ready` are low and `cfg_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configuration offered |
| cfg_ready | output | 1 | Block idle, configuration will be taken |
| cfg_mode | input | 2 | 0 pass-through, 1 whole-stream, 2 segmented |
| cfg_op | input | 2 | 0 sum, 1 min, 2 max |
| cfg_total | input | CNT_W | Number of input elements, at least 1 |
| cfg_seg | input | CNT_W | Segment length for mode 2, at least 1 |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Input element accepted at this edge |
| in_data | input | DATA_W | Signed input element |
| out_valid | output | 1 | Output result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | DATA_W | Result element |
| out_last | output | 1 | Final result of the operation |

## Verification
A result appears on the output one clock after the edge that accepts the element closing its segment. That element is every element in pass-through mode, the final element in whole-stream mode, and the segment's final element or the stream's final element in segmented mode. `cfg_ready` returns one clock after the edge that takes the output flagged last. The bench drives inputs and sets `out_ready` at the falling edge, and samples one nanosecond later. It scores a result only when valid and ready are both high at that sample, which is exactly the handshake at the next rising edge. A held stall is checked by comparing the output in the cycle after an unanswered valid with the value seen before it.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef enum logic [1:0] {
        MODE_VEC = 2'd0,
        MODE_ALL = 2'd1,
        MODE_SEG = 2'd2,
        MODE_RSV = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        OP_SUM = 2'd0,
        OP_MIN = 2'd1,
        OP_MAX = 2'd2,
        OP_RSV = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } state_e;

endpackage

// File: rtl/sr_combine.sv
module sr_combine
    import sr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_e               op,
    input  logic              first,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] elem,
    output logic [DATA_W-1:0] result
);

    logic elem_lt_acc;

    always_comb begin
        elem_lt_acc = $signed(elem) < $signed(acc);
        if (first) begin
            // a segment restarts from its own first element
            result = elem;
        end else begin
            unique case (op)
                OP_MIN:  result = elem_lt_acc ? elem : acc;
                OP_MAX:  result = elem_lt_acc ? acc : elem;
                default: result = acc + elem;
            endcase
        end
    end

endmodule

// File: rtl/sr_seq.sv
module sr_seq
    import sr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       cfg_op,
    input  logic [CNT_W-1:0] cfg_total,
    input  logic [CNT_W-1:0] cfg_seg,
    output logic             cfg_ready,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             in_fire,
    input  logic             out_free,
    input  logic             out_valid,
    input  logic             out_fire,
    input  logic             out_last,
    output logic             seg_first,
    output logic             seg_end,
    output logic             elem_final,
    output op_e              op_q,
    output mode_e            mode_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        state_e           state;
        mode_e            mode;
        op_e              op;
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] seglen;
        logic [CNT_W-1:0] elem_cnt;
        logic [CNT_W-1:0] seg_cnt;
    } seq_t;

    seq_t r_q, r_d;
    mode_e mode_in;

    always_comb begin
        r_d        = r_q;
        cfg_ready  = (r_q.state == ST_IDLE);
        seg_first  = (r_q.seg_cnt == '0);
        elem_final = (r_q.elem_cnt == r_q.total - ONE);
        seg_end    = (r_q.seg_cnt == r_q.seglen - ONE) || elem_final;
        // only a segment-closing element needs room in the output register
        in_ready   = (r_q.state == ST_RUN) && (!seg_end || out_free);
        in_fire    = in_valid && in_ready;
        mode_in    = (mode_e'(cfg_mode) == MODE_RSV) ? MODE_VEC : mode_e'(cfg_mode);

        unique case (r_q.state)
            ST_IDLE: begin
                if (cfg_valid) begin
                    r_d.state    = ST_RUN;
                    r_d.mode     = mode_in;
                    r_d.op       = (op_e'(cfg_op) == OP_RSV) ? OP_SUM : op_e'(cfg_op);
                    r_d.total    = cfg_total;
                    r_d.elem_cnt = '0;
                    r_d.seg_cnt  = '0;
                    unique case (mode_in)
                        MODE_SEG: r_d.seglen = cfg_seg;
                        MODE_ALL: r_d.seglen = cfg_total;
                        default:  r_d.seglen = ONE;
                    endcase
                end
            end
            ST_RUN: begin
                if (in_fire) begin
                    r_d.elem_cnt = r_q.elem_cnt + ONE;
                    r_d.seg_cnt  = seg_end ? '0 : r_q.seg_cnt + ONE;
                    if (elem_final) begin
                        r_d.state = ST_DRAIN;
                    end
                end
            end
            default: begin
                if (out_fire && out_last) begin
                    r_d.state = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, mode: MODE_VEC, op: OP_SUM,
                     total: ONE, seglen: ONE, elem_cnt: '0, seg_cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign op_q   = r_q.op;
    assign mode_q = r_q.mode;

    // R4: the element counter never runs past the configured total
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_IDLE) |-> (r_q.elem_cnt <= r_q.total));

    // R8: a result flagged last only exists once all input is consumed
    p_last_in_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (r_q.state == ST_DRAIN));

    // R8: taking the final result frees the block for the next operation
    p_idle_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fire && out_last) |=> cfg_ready);

endmodule

// File: rtl/sr_outbuf.sv
module sr_outbuf #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_last,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              free
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              last;
    } buf_t;

    buf_t b_q, b_d;

    always_comb begin
        b_d  = b_q;
        free = !b_q.valid || out_ready;
        if (load) begin
            b_d.valid = 1'b1;
            b_d.data  = load_data;
            b_d.last  = load_last;
        end else if (out_ready) begin
            b_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign out_valid = b_q.valid;
    assign out_data  = b_q.data;
    assign out_last  = b_q.last;

    // R7: a result that is not taken holds its value
    p_hold_under_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

endmodule

// File: rtl/seg_reduce_stream.sv
module seg_reduce_stream
    import sr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    output logic              cfg_ready,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_op,
    input  logic [CNT_W-1:0]  cfg_total,
    input  logic [CNT_W-1:0]  cfg_seg,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);

    typedef struct packed {
        logic [DATA_W-1:0] acc;
    } acc_t;

    acc_t a_q, a_d;

    logic              in_fire;
    logic              out_free;
    logic              out_fire;
    logic              seg_first;
    logic              seg_end;
    logic              elem_final;
    op_e               op_q;
    mode_e             mode_q;
    logic [DATA_W-1:0] combined;
    logic              load;

    assign out_fire = out_valid && out_ready;

    sr_seq #(.CNT_W(CNT_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_valid  (cfg_valid),
        .cfg_mode   (cfg_mode),
        .cfg_op     (cfg_op),
        .cfg_total  (cfg_total),
        .cfg_seg    (cfg_seg),
        .cfg_ready  (cfg_ready),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_fire    (in_fire),
        .out_free   (out_free),
        .out_valid  (out_valid),
        .out_fire   (out_fire),
        .out_last   (out_last),
        .seg_first  (seg_first),
        .seg_end    (seg_end),
        .elem_final (elem_final),
        .op_q       (op_q),
        .mode_q     (mode_q)
    );

    sr_combine #(.DATA_W(DATA_W)) i_combine (
        .op     (op_q),
        .first  (seg_first),
        .acc    (a_q.acc),
        .elem   (in_data),
        .result (combined)
    );

    always_comb begin
        a_d  = a_q;
        load = in_fire && seg_end;
        if (in_fire) begin
            a_d.acc = combined;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    sr_outbuf #(.DATA_W(DATA_W)) i_outbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (combined),
        .load_last (elem_final),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .free      (out_free)
    );

    // R2: in pass-through mode each accepted element is the next result
    p_vector_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && mode_q == MODE_VEC) |=> (out_valid && out_data == $past(in_data)));

endmodule

// File: tb/test_seg_reduce_stream.sv
module test_seg_reduce_stream;

    localparam int DW = 32;
    localparam int CW = 16;
    localparam int NV = 12;

    // mode, op, total, seg, seed, stall pattern
    localparam int T_MODE [NV] = '{0, 1, 1, 1, 2, 2, 2, 1, 3, 2, 1, 2};
    localparam int T_OP   [NV] = '{0, 0, 1, 2, 0, 2, 1, 3, 0, 2, 2, 0};
    localparam int T_TOT  [NV] = '{7, 10, 9, 12, 100, 11, 10, 5, 6, 6, 1, 5};
    localparam int T_SEG  [NV] = '{1, 1, 1, 1, 20, 4, 3, 1, 1, 3, 1, 8};
    localparam int T_SEED [NV] = '{1, 2, 3, 4, 5, 6, 7, 9, 1, 8, 3, 2};
    localparam int T_STL  [NV] = '{0, 0, 1, 1, 0, 1, 2, 0, 2, 0, 1, 2};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_valid = 1'b0;
    logic          cfg_ready;
    logic [1:0]    cfg_mode = '0;
    logic [1:0]    cfg_op = '0;
    logic [CW-1:0] cfg_total = '0;
    logic [CW-1:0] cfg_seg = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;
    logic          out_last;

    int total_checks = 0;
    int bad_checks = 0;
    int cyc = 0;
    int exp_data [128];
    bit exp_last [128];
    int n_exp;

    seg_reduce_stream #(.DATA_W(DW), .CNT_W(CW)) i_seg_reduce_stream (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_mode(cfg_mode),
        .cfg_op(cfg_op), .cfg_total(cfg_total), .cfg_seg(cfg_seg),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc > 50000);
        bad_checks++;
        total_checks++;
        $display("FAIL watchdog: run hung, actual cycles=%0d expected fewer", cyc);
        $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end

    task automatic check(bit ok, string req, int act, int expv);
        total_checks++;
        if (!ok) begin
            bad_checks++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int gen(int seed, int i);
        if (seed == 8) return -(100 + i);
        if (seed == 9) return 32'h7FFF_FFF0 + i;
        return ((seed * 131 + i * 47) % 97) - 48;
    endfunction

    function automatic int apply_op(int op, int a, int v);
        if (op == 1) return (v < a) ? v : a;
        if (op == 2) return (v > a) ? v : a;
        return a + v;
    endfunction

    function automatic string tag_of(int k);
        if (T_SEED[k] == 8) return "R6";
        if (T_SEED[k] == 9) return "R1";
        if (T_OP[k] == 1 || T_OP[k] == 2) return "R5";
        if (T_MODE[k] == 1) return "R3";
        if (T_MODE[k] == 2) return "R4";
        return "R2";
    endfunction

    function automatic bit ready_for(int stall);
        if (stall == 1) return cyc[0];
        if (stall == 2) return (cyc % 3) == 0;
        return 1'b1;
    endfunction

    task automatic build_expect(int k);
        int seglen;
        int pos;
        int acc;
        seglen = (T_MODE[k] == 1) ? T_TOT[k] : (T_MODE[k] == 2) ? T_SEG[k] : 1;
        n_exp = 0;
        pos = 0;
        acc = 0;
        for (int i = 0; i < T_TOT[k]; i++) begin
            int v;
            v = gen(T_SEED[k], i);
            acc = (pos == 0) ? v : apply_op(T_OP[k], acc, v);
            pos++;
            if (pos == seglen || i == T_TOT[k] - 1) begin
                exp_data[n_exp] = acc;
                exp_last[n_exp] = (i == T_TOT[k] - 1);
                n_exp++;
                pos = 0;
            end
        end
    endtask

    task automatic drive(int seed, int total);
        for (int i = 0; i < total; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = gen(seed, i);
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic recv(int stall, string tag);
        int got;
        bit held;
        logic [DW-1:0] prev_d;
        logic prev_l;
        got = 0;
        held = 1'b0;
        prev_d = '0;
        prev_l = 1'b0;
        while (got < n_exp) begin
            @(negedge clk);
            out_ready = ready_for(stall);
            #1;
            if (held) begin
                check(out_valid && out_data == prev_d && out_last == prev_l,
                      "R7 hold", int'(out_data), int'(prev_d));
            end
            held = 1'b0;
            if (out_valid) begin
                if (out_ready) begin
                    check(int'(out_data) == exp_data[got], tag, int'(out_data), exp_data[got]);
                    check(out_last == exp_last[got], {tag, " last"}, int'(out_last), int'(exp_last[got]));
                    got++;
                end else begin
                    held = 1'b1;
                    prev_d = out_data;
                    prev_l = out_last;
                end
            end
        end
        @(posedge clk);
        #1;
        out_ready = 1'b0;
    endtask

    task automatic junk_cfg();
        @(negedge clk);
        #1;
        check(!cfg_ready, "R8 busy", int'(cfg_ready), 0);
        cfg_valid = 1'b1;
        cfg_mode  = 2'd0;
        cfg_op    = 2'd0;
        cfg_total = CW'(2);
        cfg_seg   = CW'(1);
        repeat (2) @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic run_case(int k);
        build_expect(k);
        @(negedge clk);
        cfg_valid = 1'b1;
        cfg_mode  = 2'(T_MODE[k]);
        cfg_op    = 2'(T_OP[k]);
        cfg_total = CW'(T_TOT[k]);
        cfg_seg   = CW'(T_SEG[k]);
        #1;
        check(cfg_ready, "R8 idle", int'(cfg_ready), 1);
        @(posedge clk);
        fork
            drive(T_SEED[k], T_TOT[k]);
            recv(T_STL[k], tag_of(k));
            junk_cfg();
        join
        // final result taken at the previous edge: idle now
        check(cfg_ready, "R8 done", int'(cfg_ready), 1);
        check(!out_valid, "R4 count", int'(out_valid), 0);
    endtask

    initial begin
        #2;
        check(!out_valid && !in_ready && cfg_ready, "R9 reset", int'(out_valid), 0);
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!out_valid, "R9 out_valid", int'(out_valid), 0);
        check(!in_ready, "R9 in_ready", int'(in_ready), 0);
        check(cfg_ready, "R9 cfg_ready", int'(cfg_ready), 1);

        for (int k = 0; k < NV; k++) begin
            run_case(k);
        end

        // idle block ignores stray input elements
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 32'd77;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(!in_ready && !out_valid, "R8 idle input", int'(out_valid), 0);
        in_valid = 1'b0;
        out_ready = 1'b0;

        $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end

endmodule